// File: doc/BRIEF.md
# Configuration Header Bank with Base-Address Sizing

The block holds a configuration header for each function of a fixed grid of device slots (4 slots of 8 functions, each header 64 bytes by default). Software reaches it through a plain word-wide memory-mapped port. A read returns the stored word with a response valid one cycle later. A write completes in its own cycle and never stalls. Devices claim slots through an attach strobe. Slots are granted in strict order, and a request made once every slot is taken is refused.

Each slot drives, for each of its six base address registers, the size of the address window it wants and four type-flag bits. A write that falls in the base-address area of a header is not stored as written. An all-ones write is a probe and becomes a size mask: the requested size is rounded up to a power of two and the bits below it are cleared. Any other value is kept as a base address. In both cases the word is then masked by the I/O or memory address mask and the slot's flag bits are ORed in. Writes outside that area, and every read, behave as plain storage.

Top module: `cfg_header_bank`

## Requirements
- R1: After reset, word 0 of every function header (byte offset 0 within the header) reads 0x0000FFFF, the invalid-vendor code in the low 16 bits. Every other word reads 0x00000000.
- R2: A write to a word outside the base-address area is stored and read back unchanged, even when the value is all ones. The base-address area is header words 4 to 9, byte offsets 0x10 to 0x27. Offsets 0x0C and 0x28 are outside it.
- R3: A non-probe write to a base-address word of a memory window stores the value with bits [3:0] cleared, ORed with the slot's 4-bit flags. A window is a memory window when flag bit 0 is 0. Flag bits [3:1] carry the memory type and the prefetchable flag.
- R4: A non-probe write to a base-address word of an I/O window stores the value with bits [1:0] cleared, ORed with the flags. A window is an I/O window when flag bit 0 is 1.
- R5: A probe (write of 0xFFFFFFFF) to a base-address word whose slot reports size 0 stores only the flag bits.
- R6: A probe with a nonzero size S stores all ones with the low ceil(log2 S) bits cleared, then applies the R3/R4 address mask and ORs in the flags. A size that is not a power of two rounds up, so S=0x1001 gives 0xFFFFE000.
- R7: While a slot is not attached, it is treated as reporting size 0 and flags 0, whatever its size and flag inputs carry.
- R8: Each attach request pulses attach_ok one cycle later, and attach_slot then gives slot numbers 0, 1, 2 and so on in request order. Once all N_SLOTS slots are attached, a further request pulses attach_rej instead and changes no slot.
- R9: rd_valid is high exactly in the cycle after a cycle with rd_en high, and rd_data then holds the addressed word.
- R10: Byte address bits [10:9] select the slot, bits [8:6] the function and bits [5:2] the header word. Base-address register k sits at word 4+k, and its size and flag inputs come from the addressed slot's entry k. Accesses are word aligned (bits [1:0] zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| attach_req | input | 1 | Request the next free device slot |
| attach_ok | output | 1 | Attach granted (one-cycle pulse) |
| attach_rej | output | 1 | Attach refused because all slots are taken (one-cycle pulse) |
| attach_slot | output | 2 | Slot number granted with attach_ok |
| bar_size | input | 768 | Requested window size, 32 bits for each slot and register; entry s*6+k sits at bits [(s*6+k)*32 +: 32] |
| bar_flags | input | 96 | Type flags, 4 bits for each slot and register; entry s*6+k sits at bits [(s*6+k)*4 +: 4] |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 11 | Byte address within the configuration window |
| wr_data | input | 32 | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |

## Verification
The assertions check on every cycle the properties that need no knowledge of data values. These are the one-cycle read response, refusal of attaches once the slots are full, the attach count staying within its range, word alignment, and the rule that every probe mask is a run of ones above a run of zeros. Only the bench scenarios can show the actual stored values. Those include the reset contents, the rounding of sizes that are not powers of two, the difference between I/O and memory masking, the merging of flags, the zero-size and unattached-slot cases, and the limits of the base-address area at offsets 0x0C and 0x28.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam logic [31:0] IO_ADDR_MASK   = 32'hFFFF_FFFC;
  localparam logic [31:0] MEM_ADDR_MASK  = 32'hFFFF_FFF0;
  localparam logic [31:0] VENDOR_INVALID = 32'h0000_FFFF;
  localparam int          BAR_FIRST_WORD = 4;

  typedef struct packed {
    logic [31:0] size;
    logic [3:0]  flags;
  } bar_req_t;
endpackage

// File: rtl/cfg_bar_rewrite.sv
module cfg_bar_rewrite
  import cfg_hdr_pkg::*;
(
  input  logic [31:0] wdata,
  input  bar_req_t    req,
  output logic [31:0] result
);
  logic        probe;
  logic [31:0] szm1, smear, mask_raw, base, amask;

  assign probe = &wdata;
  assign szm1  = req.size - 32'd1;

  // spread the top set bit of (size-1) downward: gives 2^ceil(log2 size) - 1
  always_comb begin
    smear[31] = szm1[31];
    for (int i = 30; i >= 0; i--) smear[i] = smear[i+1] | szm1[i];
  end

  assign mask_raw = (req.size == 32'd0) ? 32'd0 : ~smear;
  assign base     = probe ? mask_raw : wdata;
  assign amask    = req.flags[0] ? IO_ADDR_MASK : MEM_ADDR_MASK;
  assign result   = (base & amask) | {28'd0, req.flags};

  always_comb begin
    if (probe && req.size != 32'd0) begin
      // R6
      pow2_mask_chk: assert (mask_raw == 32'd0 || $onehot(~mask_raw + 32'd1));
    end
  end
endmodule

// File: rtl/cfg_attach_ctr.sv
module cfg_attach_ctr #(
  parameter int N_SLOTS = 4,
  localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int CNT_W  = $clog2(N_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  output logic              ok,
  output logic              rej,
  output logic [SLOT_W-1:0] slot,
  output logic [CNT_W-1:0]  count
);
  logic full;
  assign full = (int'(count) == N_SLOTS);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      ok    <= 1'b0;
      rej   <= 1'b0;
      slot  <= '0;
    end else begin
      ok  <= req && !full;
      rej <= req && full;
      if (req && !full) begin
        slot  <= count[SLOT_W-1:0];
        count <= count + 1'b1;
      end
    end
  end

  // R8
  attach_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(count) <= N_SLOTS);
  // R8
  attach_full_chk: assert property (@(posedge clk) disable iff (rst)
    (req && full) |=> (rej && !ok && $stable(count)));
endmodule

// File: rtl/cfg_word_store.sv
module cfg_word_store
  import cfg_hdr_pkg::*;
#(
  parameter int WORDS     = 512,
  parameter int HDR_WORDS = 16,
  localparam int AW    = $clog2(WORDS),
  localparam int REG_W = $clog2(HDR_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] idx,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);
  logic [31:0]      mem [WORDS];
  logic [WORDS-1:0] wrote;
  logic [31:0]      rd_q, dflt_q;
  logic             hit_q;

  // data array carries no reset so it can map onto block RAM (read-first)
  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) rd_q <= mem[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrote  <= '0;
      hit_q  <= 1'b0;
      dflt_q <= '0;
    end else begin
      if (we) wrote[idx] <= 1'b1;
      if (re) begin
        hit_q  <= wrote[idx];
        dflt_q <= (idx[REG_W-1:0] == '0) ? VENDOR_INVALID : 32'd0;
      end
    end
  end

  assign rdata = hit_q ? rd_q : dflt_q;
endmodule

// File: rtl/cfg_header_bank.sv
module cfg_header_bank
  import cfg_hdr_pkg::*;
#(
  parameter int N_SLOTS   = 4,
  parameter int N_FUNCS   = 8,
  parameter int HDR_BYTES = 64,
  parameter int N_BARS    = 6,
  localparam int HDR_WORDS = HDR_BYTES / 4,
  localparam int REG_W     = $clog2(HDR_WORDS),
  localparam int FUNC_W    = $clog2(N_FUNCS),
  localparam int SLOT_W    = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int CNT_W     = $clog2(N_SLOTS + 1),
  localparam int ADDR_W    = SLOT_W + FUNC_W + REG_W + 2,
  localparam int WORDS     = N_SLOTS * N_FUNCS * HDR_WORDS,
  localparam int N_ENT     = N_SLOTS * N_BARS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                attach_req,
  output logic                attach_ok,
  output logic                attach_rej,
  output logic [SLOT_W-1:0]   attach_slot,
  input  logic [N_ENT*32-1:0] bar_size,
  input  logic [N_ENT*4-1:0]  bar_flags,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wr_data,
  output logic                rd_valid,
  output logic [31:0]         rd_data
);
  logic [CNT_W-1:0]  att_count;
  logic [SLOT_W-1:0] slot_of;
  logic [REG_W-1:0]  reg_of;
  logic              in_bar, present;
  int                sel;
  bar_req_t          req;
  logic [31:0]       rewritten, store_data;

  cfg_attach_ctr #(.N_SLOTS(N_SLOTS)) u_attach (
    .clk(clk), .rst(rst), .req(attach_req),
    .ok(attach_ok), .rej(attach_rej), .slot(attach_slot), .count(att_count)
  );

  assign slot_of = addr[ADDR_W-1 -: SLOT_W];
  assign reg_of  = addr[REG_W+1:2];
  assign in_bar  = (int'(reg_of) >= BAR_FIRST_WORD) &&
                   (int'(reg_of) <  BAR_FIRST_WORD + N_BARS);
  assign present = int'(slot_of) < int'(att_count);

  always_comb begin
    sel = 0;
    if (in_bar) sel = int'(slot_of) * N_BARS + (int'(reg_of) - BAR_FIRST_WORD);
    req.size  = present ? bar_size[sel*32 +: 32] : 32'd0;
    req.flags = present ? bar_flags[sel*4 +: 4]  : 4'd0;
  end

  cfg_bar_rewrite u_rewrite (.wdata(wr_data), .req(req), .result(rewritten));

  assign store_data = in_bar ? rewritten : wr_data;

  cfg_word_store #(.WORDS(WORDS), .HDR_WORDS(HDR_WORDS)) u_store (
    .clk(clk), .rst(rst), .we(wr_en), .re(rd_en),
    .idx(addr[ADDR_W-1:2]), .wdata(store_data), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd_en;
  end

  // R9
  rd_lat_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  // R9
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  // R10
  align_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en || rd_en) |-> (addr[1:0] == 2'b00));
endmodule

// File: tb/cfg_header_bank_bench.sv
module cfg_header_bank_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         attach_req = 1'b0;
  logic         attach_ok, attach_rej;
  logic [1:0]   attach_slot;
  logic [767:0] bar_size = '0;
  logic [95:0]  bar_flags = '0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [10:0]  addr = '0;
  logic [31:0]  wr_data = '0;
  logic         rd_valid;
  logic [31:0]  rd_data;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  cfg_header_bank u_cfg_header_bank (
    .clk(clk), .rst(rst), .attach_req(attach_req), .attach_ok(attach_ok),
    .attach_rej(attach_rej), .attach_slot(attach_slot), .bar_size(bar_size),
    .bar_flags(bar_flags), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%08h exp=%08h", r, got, exp);
    end
  endtask

  function automatic logic [10:0] ba(input int s, input int f, input int off);
    return 11'(s * 512 + f * 64 + off);
  endfunction

  task automatic set_bar(input int s, input int k, input logic [31:0] sz, input logic [3:0] fl);
    bar_size[(s*6+k)*32 +: 32] = sz;
    bar_flags[(s*6+k)*4 +: 4]  = fl;
  endtask

  task automatic wr(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string r, input logic [10:0] a, input logic [31:0] exp);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk({r, " rd_valid"}, {31'd0, rd_valid}, 32'd1);
    chk(r, rd_data, exp);
  endtask

  task automatic do_attach(input string r, input logic exp_ok, input logic [1:0] exp_slot);
    @(negedge clk);
    attach_req = 1'b1;
    @(negedge clk);
    attach_req = 1'b0;
    chk({r, " ok"},  {31'd0, attach_ok},  {31'd0, exp_ok});
    chk({r, " rej"}, {31'd0, attach_rej}, {31'd0, !exp_ok});
    if (exp_ok) chk({r, " slot"}, {30'd0, attach_slot}, {30'd0, exp_slot});
  endtask

  task automatic t_reset;
    chk("R9 idle rd_valid", {31'd0, rd_valid}, 32'd0);
    rd_chk("R1 vendor s0f0", ba(0, 0, 0), 32'h0000_FFFF);
    rd_chk("R1 vendor s3f7", ba(3, 7, 0), 32'h0000_FFFF);
    rd_chk("R1 word1 zero",  ba(1, 2, 4), 32'h0);
    rd_chk("R1 bar zero",    ba(2, 5, 'h14), 32'h0);
  endtask

  task automatic t_unattached;
    set_bar(3, 0, 32'h1000, 4'h8);
    wr(ba(3, 0, 'h10), 32'hFFFF_FFFF);
    rd_chk("R7 unattached probe", ba(3, 0, 'h10), 32'h0);
    wr(ba(3, 0, 'h10), 32'h1234_5678);
    rd_chk("R7 unattached addr", ba(3, 0, 'h10), 32'h1234_5670);
  endtask

  task automatic t_attach_first;
    do_attach("R8 attach0", 1'b1, 2'd0);
    do_attach("R8 attach1", 1'b1, 2'd1);
    do_attach("R8 attach2", 1'b1, 2'd2);
  endtask

  task automatic t_plain;
    wr(ba(0, 2, 0), 32'h1234_5678);
    rd_chk("R2 vendor overwrite", ba(0, 2, 0), 32'h1234_5678);
    wr(ba(0, 0, 'h0C), 32'hFFFF_FFFF);
    rd_chk("R2 below bar area", ba(0, 0, 'h0C), 32'hFFFF_FFFF);
    wr(ba(0, 0, 'h28), 32'hFFFF_FFFF);
    rd_chk("R2 above bar area", ba(0, 0, 'h28), 32'hFFFF_FFFF);
  endtask

  task automatic t_base;
    set_bar(0, 0, 32'h100, 4'h8);
    wr(ba(0, 0, 'h10), 32'hABCD_1237);
    rd_chk("R3 mem base", ba(0, 0, 'h10), 32'hABCD_1238);
    set_bar(1, 2, 32'h10, 4'h1);
    wr(ba(1, 0, 'h18), 32'h0000_1236);
    rd_chk("R4 io base", ba(1, 0, 'h18), 32'h0000_1235);
  endtask

  task automatic t_probe;
    set_bar(0, 1, 32'h1000, 4'h0);
    wr(ba(0, 1, 'h14), 32'hFFFF_FFFF);
    rd_chk("R6 pow2 size", ba(0, 1, 'h14), 32'hFFFF_F000);
    set_bar(0, 1, 32'h1001, 4'h0);
    wr(ba(0, 1, 'h14), 32'hFFFF_FFFF);
    rd_chk("R6 round up", ba(0, 1, 'h14), 32'hFFFF_E000);
    set_bar(0, 2, 32'd5, 4'h0);
    wr(ba(0, 0, 'h18), 32'hFFFF_FFFF);
    rd_chk("R6 small mem", ba(0, 0, 'h18), 32'hFFFF_FFF0);
    set_bar(1, 3, 32'd5, 4'h1);
    wr(ba(1, 0, 'h1C), 32'hFFFF_FFFF);
    rd_chk("R6 small io", ba(1, 0, 'h1C), 32'hFFFF_FFF9);
    set_bar(1, 4, 32'd1, 4'h1);
    wr(ba(1, 0, 'h20), 32'hFFFF_FFFF);
    rd_chk("R6 size one io", ba(1, 0, 'h20), 32'hFFFF_FFFD);
    set_bar(2, 0, 32'd0, 4'h0);
    wr(ba(2, 0, 'h10), 32'hFFFF_FFFF);
    rd_chk("R5 size zero", ba(2, 0, 'h10), 32'h0);
    set_bar(2, 1, 32'd0, 4'h1);
    wr(ba(2, 0, 'h14), 32'hFFFF_FFFF);
    rd_chk("R5 size zero flags", ba(2, 0, 'h14), 32'h1);
  endtask

  task automatic t_decode;
    set_bar(2, 5, 32'h40, 4'h6);
    wr(11'h5E4, 32'hFFFF_FFFF);
    rd_chk("R10 s2f7 bar5", 11'h5E4, 32'hFFFF_FFC6);
    rd_chk("R10 s2f0 bar5 untouched", ba(2, 0, 'h24), 32'h0);
  endtask

  task automatic t_full;
    set_bar(3, 0, 32'h1000, 4'h8);
    do_attach("R8 attach3", 1'b1, 2'd3);
    wr(ba(3, 0, 'h10), 32'hFFFF_FFFF);
    rd_chk("R7 attached probe", ba(3, 0, 'h10), 32'hFFFF_F008);
    do_attach("R8 reject", 1'b0, 2'd0);
    do_attach("R8 reject again", 1'b0, 2'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_unattached();
    t_attach_first();
    t_plain();
    t_base();
    t_probe();
    t_decode();
    t_full();
    @(negedge clk);
    chk("R9 rd_valid drops", {31'd0, rd_valid}, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule